// File: doc/BRIEF.md
# Stepped Wiper Position Controller with Retained Setting

This block is the digital control core of a stepped potentiometer with 32 positions. A host drives three pins: an active-low select, a direction level and an increment strobe. These pins arrive without any relation to the system clock, so the block resynchronises them. It tracks the wiper position in a counter that saturates at both ends. The position is decoded into a one-hot tap select, which drives the switch network of a resistor array located elsewhere.

A register models the retained (non-volatile) setting. The level of the strobe line at the moment select is released decides whether the live position is saved. A save starts a timed busy window, and the block then drops into standby. A power-on reset, or a separate recall pulse, copies the saved setting back into the counter. Only a dedicated initialise pulse clears the saved setting.

Top module: `wiper_ctrl`

## Requirements
- R1: `tap_sel_o` always has exactly one bit set, and that bit's index equals `pos_o` (bit 0 is the lowest position).
- R2: A 1-to-0 transition of `step_i` while `sel_n_i` is 0 moves the position by one: up when `dir_i` is 1, down when `dir_i` is 0. The new value appears on `pos_o` after the third rising clock edge following the input change, because each pin passes through two flops.
- R3: The position saturates. A step down at 0 or a step up at TAPS-1 leaves it unchanged, and it never wraps.
- R4: Strobe transitions have no effect on the position while `sel_n_i` is 1.
- R5: When `sel_n_i` rises while `step_i` is 1, the current position is saved and `busy_o` is 1 for exactly STORE_CYCLES clock cycles.
- R6: When `sel_n_i` rises while `step_i` is 0, nothing is saved, the position is kept, and `standby_o` becomes 1 without a busy window.
- R7: While `busy_o` is 1, strobe transitions do not move the position, even if select is low again.
- R8: `standby_o` is 1 after reset and after a deselect. It is 0 while the synchronised select is low and throughout the busy window. When a save ends, it follows the select level.
- R9: A `recall_i` pulse loads the saved setting into the position. It takes priority over a strobe edge that falls in the same cycle.
- R10: While `rst_n` is 0, the position is loaded from the saved setting, which survives reset. An `init_i` pulse clears the saved setting to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset; recalls the saved setting |
| sel_n_i | input | 1 | Active-low select pin, asynchronous |
| dir_i | input | 1 | Direction pin: 1 up, 0 down, asynchronous |
| step_i | input | 1 | Increment strobe pin, acts on its falling edge, asynchronous |
| recall_i | input | 1 | Synchronous pulse: load saved setting into the position |
| init_i | input | 1 | Synchronous pulse: clear saved setting to 0 |
| tap_sel_o | output | TAPS | One-hot tap select |
| pos_o | output | $clog2(TAPS) | Binary wiper position |
| busy_o | output | 1 | Save window in progress |
| standby_o | output | 1 | Block deselected and idle |

## Verification
A recall pulse and a detected strobe edge can both land on the same clock edge and compete for the position register. The bench provokes this by placing the recall pulse exactly on the cycle in which the synchronised strobe first reads low. It then expects the saved value, not a value one step away. A second collision occurs when the host reselects the block and sends strobes during the busy window. The bench expects the position to stay frozen there, and expects standby to track the select level when the window closes.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

    // Saturating one-step move within [0, top]
    function automatic int unsigned sat_step(int unsigned pos, logic up, int unsigned top);
        if (up)
            return (pos >= top) ? top : pos + 1;
        else
            return (pos == 0) ? 0 : pos - 1;
    endfunction

endpackage

// File: rtl/wiper_sync.sv
module wiper_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
        end
    end

    assign sync_o = sync_q;
endmodule

// File: rtl/wiper_decode.sv
module wiper_decode #(
    parameter int TAPS  = 32,
    parameter int POS_W = $clog2(TAPS)
) (
    input  logic [POS_W-1:0] pos_i,
    output logic [TAPS-1:0]  tap_o
);
    for (genvar t = 0; t < TAPS; t++) begin : g_tap
        assign tap_o[t] = (pos_i == POS_W'(t));
    end
endmodule

// File: rtl/wiper_ctrl.sv
module wiper_ctrl #(
    parameter int TAPS         = 32,
    parameter int STORE_CYCLES = 500000,
    localparam int POS_W       = $clog2(TAPS),
    localparam int CNT_W       = $clog2(STORE_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_n_i,
    input  logic             dir_i,
    input  logic             step_i,
    input  logic             recall_i,
    input  logic             init_i,
    output logic [TAPS-1:0]  tap_sel_o,
    output logic [POS_W-1:0] pos_o,
    output logic             busy_o,
    output logic             standby_o
);
    import wiper_pkg::*;

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic             standby;
        logic             sel_n_prev;
        logic             step_prev;
    } ctrl_t;

    ctrl_t            st_q, st_d;
    logic [POS_W-1:0] saved_q;
    logic             save_en;
    logic             s_sel_n, s_dir, s_step;
    logic [2:0]       sync_vec;

    wiper_sync #(.W(3), .RST_VAL(3'b101)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sel_n_i, dir_i, step_i}),
        .sync_o  (sync_vec)
    );
    assign s_sel_n = sync_vec[2];
    assign s_dir   = sync_vec[1];
    assign s_step  = sync_vec[0];

    always_comb begin
        logic desel_edge;
        logic step_fall;
        st_d       = st_q;
        save_en    = 1'b0;
        desel_edge = s_sel_n & ~st_q.sel_n_prev;
        step_fall  = ~s_step & st_q.step_prev;

        if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                st_d.busy    = 1'b0;
                st_d.standby = s_sel_n;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end else if (desel_edge) begin
            if (s_step) begin
                save_en   = 1'b1;
                st_d.busy = 1'b1;
                st_d.cnt  = CNT_W'(STORE_CYCLES - 1);
            end else begin
                st_d.standby = 1'b1;
            end
        end
        if (!s_sel_n)
            st_d.standby = 1'b0;

        if (recall_i)
            st_d.pos = saved_q;
        else if (step_fall && !s_sel_n && !st_q.busy)
            st_d.pos = POS_W'(sat_step(int'(st_q.pos), s_dir, TAPS - 1));

        st_d.sel_n_prev = s_sel_n;
        st_d.step_prev  = s_step;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pos        <= saved_q;
            st_q.busy       <= 1'b0;
            st_q.cnt        <= '0;
            st_q.standby    <= 1'b1;
            st_q.sel_n_prev <= 1'b1;
            st_q.step_prev  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    // Retained setting: survives reset, cleared only by init_i
    always_ff @(posedge clk) begin
        if (init_i)
            saved_q <= '0;
        else if (save_en)
            saved_q <= st_q.pos;
    end

    wiper_decode #(.TAPS(TAPS), .POS_W(POS_W)) u_dec (
        .pos_i (st_q.pos),
        .tap_o (tap_sel_o)
    );

    assign pos_o     = st_q.pos;
    assign busy_o    = st_q.busy;
    assign standby_o = st_q.standby;
endmodule

// File: rtl/wiper_ctrl_chk.sv
module wiper_ctrl_chk #(
    parameter int TAPS = 32,
    localparam int POS_W = $clog2(TAPS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sel_n_i,
    input logic             recall_i,
    input logic [TAPS-1:0]  tap_sel_o,
    input logic [POS_W-1:0] pos_o,
    input logic             busy_o,
    input logic             standby_o
);
    logic [POS_W:0] pos_x;
    assign pos_x = {1'b0, pos_o};

    // R1
    a_r1_onehot_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(tap_sel_o) && tap_sel_o[pos_o]);

    // R3: at most one step per cycle, no wrap across the ends
    a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(recall_i) |->
            (pos_x == {1'b0, $past(pos_o)}) ||
            (pos_x == {1'b0, $past(pos_o)} + 1'b1) ||
            (pos_x + 1'b1 == {1'b0, $past(pos_o)}));

    // R4: deselected three cycles earlier means no move
    a_r4_desel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(sel_n_i, 3) && !$past(recall_i) |-> pos_o == $past(pos_o));

    // R7
    a_r7_busy_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(busy_o) && !$past(recall_i) |-> pos_o == $past(pos_o));

    // R8
    a_r8_busy_not_standby: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !standby_o);
endmodule

bind wiper_ctrl wiper_ctrl_chk #(.TAPS(TAPS)) u_chk (.*);

// File: tb/wiper_ctrl_tb_top.sv
module wiper_ctrl_tb_top;
    localparam int TAPS = 32;
    localparam int NCYC = 40;
    localparam int PW   = $clog2(TAPS);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_n = 1'b1, dir = 1'b0, step = 1'b1, recall = 1'b0, init = 1'b0;
    logic [TAPS-1:0] tap_sel;
    logic [PW-1:0]   pos;
    logic            busy, standby;

    int checks = 0, errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    wiper_ctrl #(.TAPS(TAPS), .STORE_CYCLES(NCYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .sel_n_i(sel_n), .dir_i(dir), .step_i(step),
        .recall_i(recall), .init_i(init), .tap_sel_o(tap_sel), .pos_o(pos),
        .busy_o(busy), .standby_o(standby));

    // Behavioural reference model
    int m_pos = 0, m_saved = 0, m_cnt = 0;
    bit m_busy = 0, m_stby = 1;
    bit a1_sel = 1, a1_dir = 0, a1_step = 1;   // first sync stage
    bit a2_sel = 1, a2_dir = 0, a2_step = 1;   // second sync stage
    bit p_sel = 1, p_step = 1;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pos = m_saved; m_busy = 0; m_cnt = 0; m_stby = 1;
            a1_sel = 1; a2_sel = 1; a1_dir = 0; a2_dir = 0; a1_step = 1; a2_step = 1;
            p_sel = 1; p_step = 1;
            if (clk && init) m_saved = 0;
        end else begin
            int nsaved;
            bit was_busy;
            nsaved = init ? 0 : m_saved;
            was_busy = m_busy;
            if (m_busy) begin
                if (m_cnt == 0) begin m_busy = 0; m_stby = a2_sel; end
                else m_cnt--;
            end else if (a2_sel && !p_sel) begin
                if (a2_step) begin
                    if (!init) nsaved = m_pos;
                    m_busy = 1; m_cnt = NCYC - 1;
                end else m_stby = 1;
            end
            if (!a2_sel) m_stby = 0;
            if (recall) m_pos = m_saved;
            else if (!a2_step && p_step && !a2_sel && !was_busy) begin
                if (a2_dir) m_pos = (m_pos == TAPS - 1) ? m_pos : m_pos + 1;
                else        m_pos = (m_pos == 0) ? 0 : m_pos - 1;
            end
            m_saved = nsaved;
            p_sel = a2_sel; p_step = a2_step;
            a2_sel = a1_sel; a2_dir = a1_dir; a2_step = a1_step;
            a1_sel = sel_n; a1_dir = dir; a1_step = step;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(tap_sel == (TAPS'(1) << m_pos), "R1 tap_sel", int'(tap_sel), 1 << m_pos);
            chk(int'(pos) == m_pos, "R2 pos", int'(pos), m_pos);
            chk(busy == m_busy, "R5 busy", int'(busy), int'(m_busy));
            chk(standby == m_stby, "R8 standby", int'(standby), int'(m_stby));
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input bit up);
        dir = up; cyc(1);
        step = 1'b0; cyc(3);
        step = 1'b1; cyc(3);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cyc(3);
        rst_n = 1'b1; cyc(1);
    endtask

    initial begin
        cyc(1);
        init = 1'b1; @(posedge clk); cyc(1); init = 1'b0;
        cyc(2);
        rst_n = 1'b1; cyc(1);
        chk(pos == 0 && tap_sel == 1, "R10 reset pos after init", int'(pos), 0);
        chk(standby && !busy, "R8 reset standby", int'(standby), 1);

        sel_n = 1'b0; cyc(4);
        chk(!standby, "R8 selected clears standby", int'(standby), 0);
        repeat (5) pulse(1'b1);
        chk(pos == 5, "R2 up steps", int'(pos), 5);
        repeat (2) pulse(1'b0);
        chk(pos == 3, "R2 down steps", int'(pos), 3);
        repeat (5) pulse(1'b0);
        chk(pos == 0, "R3 floor", int'(pos), 0);
        repeat (36) pulse(1'b1);
        chk(pos == TAPS - 1 && tap_sel[TAPS-1], "R3 ceiling", int'(pos), TAPS - 1);
        repeat (11) pulse(1'b0);
        chk(pos == 20, "R2 back to 20", int'(pos), 20);

        // save with step high, reselect and strobe while busy
        sel_n = 1'b1; cyc(4);
        chk(busy == 1'b1, "R5 busy after save", int'(busy), 1);
        sel_n = 1'b0; cyc(3);
        repeat (3) pulse(1'b1);
        chk(pos == 20 && busy, "R7 frozen while busy", int'(pos), 20);
        cyc(NCYC);
        chk(!busy && !standby, "R8 save ends selected", int'(standby), 0);

        // move then deselect with step low: no save
        repeat (5) pulse(1'b1);
        step = 1'b0; cyc(3);
        chk(pos == 26, "R2 extra fall while selected", int'(pos), 26);
        sel_n = 1'b1; cyc(4);
        chk(standby && !busy && pos == 26, "R6 no-save deselect", int'(busy), 0);
        step = 1'b1; cyc(3);
        repeat (3) pulse(1'b0);
        chk(pos == 26, "R4 ignored while deselected", int'(pos), 26);
        do_reset();
        chk(pos == 20, "R10 reset recalls saved", int'(pos), 20);

        // recall colliding with a strobe edge
        sel_n = 1'b0; cyc(4);
        repeat (4) pulse(1'b0);
        chk(pos == 16, "R2 before recall", int'(pos), 16);
        dir = 1'b1; cyc(1);
        step = 1'b0; cyc(2);
        recall = 1'b1; cyc(1); recall = 1'b0;
        cyc(2);
        chk(pos == 20, "R9 recall beats strobe", int'(pos), 20);
        step = 1'b1; cyc(3);

        // save ending while deselected
        pulse(1'b1);
        sel_n = 1'b1; cyc(4);
        chk(busy && !standby, "R5 second save busy", int'(busy), 1);
        cyc(NCYC);
        chk(!busy && standby, "R8 standby after save", int'(standby), 1);

        // initialise then recall
        init = 1'b1; cyc(1); init = 1'b0;
        recall = 1'b1; cyc(1); recall = 1'b0;
        cyc(1);
        chk(pos == 0, "R10 init clears saved", int'(pos), 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule